// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog with a "too early" window, clocked by the system clock. A single-cycle enable pulse stands in for a slow reference clock of about 32 kHz. That clock is assumed to be already synchronized to the system clock. A small prescaler divides the slow tick by a value from 1 to 8, and a 25-bit counter advances once for each divided tick. The period is chosen from eight power-of-two values. Software must send a restart strobe before the counter reaches the end of the period, or the block raises a one-cycle violation pulse.

The beginning of each period can be a closed window. The configuration word holds two window codes, and a select bit picks which one is in force. A restart that arrives while the counter is still inside the closed part is treated as a fault, in the same way as a timeout. After any violation the counter freezes until the enable is dropped and raised again. A legal restart, and the first start, resynchronize to the next slow tick before the count begins again at zero. For four slow ticks after such a point, a change of the select bit is held off.

Top module: `winwdog_top`

## Requirements
- R1: After reset, `count_o` is 0 and `viol_o` is 0. While `en_i` is low, the counter holds 0, and ticks and restart strobes cause no violation.
- R2: The prescaler field `cfg_i[2:0]` (value d) sets the rate: the counter advances by one on every (d+1)-th slow tick.
- R3: The period field `cfg_i[5:3]` (codes 0..7) sets the period P to 2^25, 2^21, 2^18, 2^15, 2^12, 2^10, 2^8 and 2^6 in that order. With no restart, the timeout violation occurs on slow tick P*(d+1) after the start tick, and the count stays at P-1.
- R4: Once enabled, the counter waits for the next slow tick, called the start tick. At the start tick it reads 0, and it begins advancing from there.
- R5: The window codes sit in `cfg_i[8:6]` (window 0) and `cfg_i[11:9]` (window 1). Codes 1..7 close the first 1/8, 3/16, 1/4, 1/2, 3/4, 13/16 and 7/8 of P. A restart with the count below that threshold is a violation. A restart at or above the threshold clears the count to 0 with no violation.
- R6: Window code 0 has no closed part, so a restart is legal at any count.
- R7: `win_sel_i` = 0 selects window 0 and 1 selects window 1. After a start or a legal restart, a change of `win_sel_i` takes effect only after four slow ticks.
- R8: After a violation, the count stays frozen and no further violation occurs until `en_i` goes low.
- R9: `viol_o` is registered and high for exactly one clock, in the cycle after the edge where the timeout or the early restart is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle slow-clock enable pulse |
| cfg_i | input | 12 | {window1, window0, period, prescaler}, 3 bits each |
| win_sel_i | input | 1 | Selects the active window code |
| en_i | input | 1 | Watchdog enable; low stops and clears the counter |
| restart_i | input | 1 | Restart strobe, one cycle |
| viol_o | output | 1 | One-cycle violation pulse |
| count_o | output | 25 | Live counter value |

## Verification
The outputs expose the internal state quickly. A wrong prescaler phase or period limit moves the timeout pulse to a different slow tick, and the bench predicts that tick exactly. A wrong window threshold shows up as a missing or extra violation pulse. The bench probes each threshold one count below and exactly at its value, so the error is visible in the clock after the restart. A lock on the select bit that is too short or too long makes a restart give the wrong verdict within a few ticks. A counter that fails to freeze after a violation shows up on `count_o` at the next divided tick.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;

  typedef enum logic [1:0] {WD_IDLE, WD_SYNC, WD_RUN, WD_HALT} wd_state_e;

  // Power-of-two exponent of the period for each period code.
  function automatic int unsigned per_shift(input logic [2:0] code);
    case (code)
      3'd0: return 25;
      3'd1: return 21;
      3'd2: return 18;
      3'd3: return 15;
      3'd4: return 12;
      3'd5: return 10;
      3'd6: return 8;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/winwdog_limits.sv
module winwdog_limits
  import winwdog_pkg::*;
#(
  parameter int CNT_W  = 25,
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] per_i,
  input  logic [CODE_W-1:0] win_i,
  output logic [CNT_W-1:0]  last_o,
  output logic [CNT_W:0]    thr_o
);
  logic [CNT_W:0] p;
  logic [CNT_W:0] pm1;

  always_comb begin
    p      = {{CNT_W{1'b0}}, 1'b1} << per_shift(per_i[2:0]);
    pm1    = p - 1'b1;
    last_o = pm1[CNT_W-1:0];
    // closed fraction built only from shifts of the period
    case (win_i[2:0])
      3'd0: thr_o = '0;
      3'd1: thr_o = p >> 3;
      3'd2: thr_o = (p >> 3) + (p >> 4);
      3'd3: thr_o = p >> 2;
      3'd4: thr_o = p >> 1;
      3'd5: thr_o = (p >> 1) + (p >> 2);
      3'd6: thr_o = (p >> 1) + (p >> 2) + (p >> 4);
      default: thr_o = p - (p >> 3);
    endcase
  end
endmodule

// File: rtl/winwdog_prescale.sv
module winwdog_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q >= div_i);
  assign step_o = run_i && tick_i && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run_i) pre_q <= '0;
    else if (tick_i)   pre_q <= wrap ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/winwdog_winsel.sv
module winwdog_winsel #(
  parameter int LOCK_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic tick_i,
  input  logic sel_i,
  output logic sel_o
);
  localparam int LOCK_W = $clog2(LOCK_TICKS + 1);
  logic [LOCK_W-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      sel_o  <= 1'b0;
    end else begin
      if (arm_i)                       lock_q <= LOCK_W'(LOCK_TICKS);
      else if (tick_i && lock_q != '0) lock_q <= lock_q - 1'b1;
      if (!arm_i && lock_q == '0)      sel_o  <= sel_i;
    end
  end

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q != '0) |=> $stable(sel_o));
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
  import winwdog_pkg::*;
#(
  parameter int CNT_W      = 25,
  parameter int DIV_W      = 3,
  parameter int CODE_W     = 3,
  parameter int LOCK_TICKS = 4,
  localparam int CFG_W     = DIV_W + 3 * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             win_sel_i,
  input  logic             en_i,
  input  logic             restart_i,
  output logic             viol_o,
  output logic [CNT_W-1:0] count_o
);
  wd_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               viol_q;
  logic [DIV_W-1:0]   div;
  logic [CODE_W-1:0]  per, win0, win1, win_code;
  logic [CNT_W-1:0]   last;
  logic [CNT_W:0]     thr;
  logic               sel_eff, step, early, live, rst_bad, rst_ok, arm, run;

  assign div      = cfg_i[DIV_W-1:0];
  assign per      = cfg_i[DIV_W +: CODE_W];
  assign win0     = cfg_i[DIV_W+CODE_W +: CODE_W];
  assign win1     = cfg_i[DIV_W+2*CODE_W +: CODE_W];
  assign win_code = sel_eff ? win1 : win0;

  assign early   = ({1'b0, cnt_q} < thr);
  assign live    = (state_q == WD_SYNC) || (state_q == WD_RUN);
  assign rst_bad = en_i && live && restart_i && early;
  assign rst_ok  = en_i && live && restart_i && !early;
  assign arm     = (en_i && state_q == WD_IDLE) || rst_ok;
  assign run     = en_i && (state_q == WD_RUN);

  winwdog_limits #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_lim (
    .per_i(per), .win_i(win_code), .last_o(last), .thr_o(thr));

  winwdog_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(tick_i), .div_i(div), .step_o(step));

  winwdog_winsel #(.LOCK_TICKS(LOCK_TICKS)) u_sel (
    .clk(clk), .rst(rst), .arm_i(arm), .tick_i(tick_i), .sel_i(win_sel_i), .sel_o(sel_eff));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= 1'b0;
      if (!en_i) begin
        state_q <= WD_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          WD_IDLE: state_q <= WD_SYNC;
          WD_SYNC: begin
            if (rst_bad) begin
              viol_q  <= 1'b1;
              state_q <= WD_HALT;
            end else if (!restart_i && tick_i) begin
              state_q <= WD_RUN;
            end
          end
          WD_RUN: begin
            if (rst_bad) begin
              viol_q  <= 1'b1;
              state_q <= WD_HALT;
            end else if (rst_ok) begin
              state_q <= WD_SYNC;
              cnt_q   <= '0;
            end else if (step) begin
              if (cnt_q >= last) begin
                viol_q  <= 1'b1;
                state_q <= WD_HALT;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: state_q <= WD_HALT;
        endcase
      end
    end
  end

  assign viol_o  = viol_q;
  assign count_o = cnt_q;

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0 && !viol_q));
  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_RUN && en_i && !restart_i) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R5
  early_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_RUN && en_i && restart_i && early) |=> viol_q);
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_HALT && en_i) |=> ($stable(cnt_q) && !viol_q));
  // R9
  viol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    viol_q |=> !viol_q);
endmodule

// File: tb/tb_winwdog_top.sv
module tb_winwdog_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [11:0] cfg = '0;
  logic        win_sel = 1'b0;
  logic        en = 1'b0;
  logic        restart = 1'b0;
  logic        viol;
  logic [24:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;
  int tick_no = 0;
  bit done = 0;
  bit prev_viol = 0;
  int    exp_q[$];
  string tag_q[$];

  winwdog_top dut (.clk(clk), .rst(rst), .tick_i(tick), .cfg_i(cfg), .win_sel_i(win_sel),
                   .en_i(en), .restart_i(restart), .viol_o(viol), .count_o(count));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ph   = (ph == 2) ? 0 : ph + 1;
    tick = (ph == 0);
  end

  always @(posedge clk) if (tick) tick_no <= tick_no + 1;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each violation pulse with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (viol) begin
        chk("R9 single-cycle pulse", !prev_viol, 1, 0);
        if (exp_q.size() == 0) chk("unexpected violation", 1'b0, tick_no, -1);
        else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, tick_no == e, tick_no, e);
        end
      end
      prev_viol = viol;
    end
  end

  function automatic logic [11:0] mk(input int d, input int p, input int w0, input int w1);
    return {w1[2:0], w0[2:0], p[2:0], d[2:0]};
  endfunction

  function automatic int thr_of(input int w);
    case (w)
      1: return 8;  2: return 12; 3: return 16; 4: return 32;
      5: return 48; 6: return 52; 7: return 56; default: return 0;
    endcase
  endfunction

  task automatic after_tick();
    @(posedge clk);
    while (tick !== 1'b1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(output int s);
    after_tick();
    en = 1'b1;
    s  = tick_no + 1;
  endtask

  task automatic stop();
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_count(input int v);
    int guard = 0;
    after_tick();
    while (count != v && guard < 5000) begin
      after_tick();
      guard++;
    end
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic expect_viol(input int idx, input string t);
    exp_q.push_back(idx);
    tag_q.push_back(t);
  endtask

  task automatic run_timeout(input int d, input int p);
    int s, pc;
    int sh[8] = '{25, 21, 18, 15, 12, 10, 8, 6};
    stop();
    cfg = mk(d, p, 0, 0);
    pc  = 1 << sh[p];
    start(s);
    expect_viol(s + pc * (d + 1), "R3 timeout tick");
    while (exp_q.size() != 0) @(negedge clk);
    chk("R3 count at timeout", count == pc - 1, count, pc - 1);
    repeat (3 * (d + 1) * 3) @(negedge clk);
    chk("R8 frozen after timeout", count == pc - 1, count, pc - 1);
  endtask

  initial begin
    int s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset count", count == 0, count, 0);
    chk("R1 reset viol", viol == 1'b0, viol, 0);

    // R1: disabled block ignores ticks and restarts
    cfg = mk(0, 7, 7, 7);
    repeat (3) begin after_tick(); pulse_restart(); end
    repeat (6) @(negedge clk);
    chk("R1 disabled count", count == 0, count, 0);
    chk("R1 disabled no viol", exp_q.size() == 0 && !viol, viol, 0);

    // R4 start tick and R2 prescaler rate
    cfg = mk(2, 7, 0, 0);
    start(s);
    @(negedge clk);
    chk("R4 zero while syncing", count == 0, count, 0);
    while (tick_no < s + 1) after_tick();
    chk("R4 zero after start tick", count == 0, count, 0);
    while (tick_no < s + 14) after_tick();
    chk("R2 count at 14 ticks div3", count == 4, count, 4);
    after_tick();
    chk("R2 count at 15 ticks div3", count == 5, count, 5);

    // R3 timeouts for several period/prescaler pairs
    run_timeout(0, 7);
    run_timeout(3, 7);
    run_timeout(1, 6);
    run_timeout(0, 5);
    run_timeout(7, 6);

    // R5 each window code: one below threshold is early, at threshold is legal
    for (int w = 1; w < 8; w++) begin
      int t;
      t = thr_of(w);
      stop();
      cfg = mk(0, 7, w, 0);
      win_sel = 1'b0;
      start(s);
      wait_count(t - 1);
      expect_viol(tick_no, $sformatf("R5 early restart code %0d", w));
      pulse_restart();
      repeat (3) @(negedge clk);
      chk("R5 early violation seen", exp_q.size() == 0, exp_q.size(), 0);
      after_tick(); after_tick();
      chk("R8 frozen after early restart", count == t - 1, count, t - 1);
      stop();
      start(s);
      wait_count(t);
      pulse_restart();
      chk($sformatf("R5 legal restart code %0d", w), count == 0, count, 0);
      wait_count(2);
      chk("R5 counting after legal restart", count == 2, count, 2);
    end

    // R6 window code 0
    stop();
    cfg = mk(0, 7, 0, 0);
    start(s);
    wait_count(0);
    pulse_restart();
    chk("R6 restart at count 0", count == 0, count, 0);
    wait_count(63);
    pulse_restart();
    chk("R6 restart at count 63", count == 0, count, 0);
    wait_count(3);
    chk("R6 no violation", exp_q.size() == 0, exp_q.size(), 0);

    // R7 select hold-off after restart, then selection takes effect
    stop();
    cfg = mk(0, 7, 0, 7);
    win_sel = 1'b0;
    start(s);
    wait_count(3);
    pulse_restart();
    win_sel = 1'b1;
    wait_count(1);
    pulse_restart();
    chk("R7 select held during lock", count == 0, count, 0);
    wait_count(5);
    expect_viol(tick_no, "R7 window1 active after lock");
    pulse_restart();
    repeat (3) @(negedge clk);
    chk("R7 window1 violation seen", exp_q.size() == 0, exp_q.size(), 0);

    // R8 re-enable recovers
    stop();
    chk("R8 cleared by disable", count == 0, count, 0);

    repeat (4) @(negedge clk);
    chk("end: no pending violations", exp_q.size() == 0, exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule